// File: doc/BRIEF.md
# Receive mailbox lock arbiter

This block keeps a small array of receive mailboxes and guards each one against being overwritten while the host is reading it. Every mailbox holds a 4-bit state code and a payload of several words. A host read of a mailbox's status word puts an implicit lock on that mailbox. The host releases the lock by reading the free-running timer or by reading the status word of some other mailbox. Only one mailbox can be locked at any time.

An upstream matcher hands in each accepted frame together with the index of its target mailbox. The frame first lands in one shared staging register. From there a serial mover copies it into the mailbox one payload word per cycle, and the mailbox shows its BUSY bit while the copy runs. A frame aimed at the locked mailbox waits in staging until the lock goes away. A newer frame replaces the waiting one without any trace. Each mailbox also has a deactivate strobe. The strobe retires the mailbox, drops its lock and drops any frame waiting for it.

Top module: `mb_lock_arbiter`

## Requirements
- R1: After reset every mailbox code reads as INACTIVE (4'b0000) and every payload word reads as zero.
- R2: A status-word read (select 0) of a receive mailbox holding data (code bit 3 clear, not 4'b0000, not 4'b0100, BUSY bit 0 clear, e.g. FULL 4'b0010) locks it. Frames aimed at the locked mailbox leave its code and payload unchanged for as long as the lock holds.
- R3: A timer read (select 2) releases the lock. A frame waiting for the released mailbox starts its move one cycle after the release takes effect.
- R4: A status-word read of a different mailbox releases the current lock and locks the newly read mailbox if that mailbox is eligible. Reading the locked mailbox again keeps the lock.
- R5: A status-word read never locks a mailbox whose code is INACTIVE 4'b0000, EMPTY 4'b0100, a transmit code (bit 3 set, e.g. 4'b1000), or a code with BUSY (bit 0) set.
- R6: A frame aimed at an unlocked receive mailbox is staged on the first clock edge and starts its move on the next edge. The mailbox code then reads as its previous value with bit 0 set for exactly WORDS cycles, and afterwards as FULL 4'b0010. Payload word k (read through select 1) equals bits [k*DATA_W +: DATA_W] of the frame.
- R7: A second frame that arrives while the first still waits in staging replaces it. The mailbox then ends up with the second frame and code FULL 4'b0010, with no lost-frame marking.
- R8: A deactivate strobe sets the mailbox code to INACTIVE, clears a lock held on it and discards a frame staged for it.
- R9: A deactivate strobe during a move aborts the move, and the mailbox code stays INACTIVE afterwards.
- R10: The timer counts up by one every cycle, and a timer read returns its value zero-extended.
- R11: A host write with select 0 sets the addressed mailbox code to write data bits [3:0], unless that mailbox is the target of a move in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| hst_rd_en_i | input | 1 | Host read strobe; carries the lock side effects |
| hst_wr_en_i | input | 1 | Host write strobe; with select 0 writes a mailbox code |
| hst_sel_i | input | 2 | 0 status word, 1 payload word, 2 timer |
| hst_mb_i | input | IDX_W | Mailbox index of the host access |
| hst_word_i | input | CNT_W | Payload word index for select 1 |
| hst_wdata_i | input | DATA_W | Host write data; bits [3:0] form the code |
| hst_rdata_o | output | DATA_W | Read data for the current select, combinational |
| rx_valid_i | input | 1 | A matched frame is present this cycle |
| rx_mb_i | input | IDX_W | Target mailbox of the frame |
| rx_payload_i | input | WORDS*DATA_W | Frame payload, word 0 in the low bits |
| mb_deact_i | input | NUM_MB | Per-mailbox deactivate strobe |

## Verification
The bench builds the block with four mailboxes, three payload words of 16 bits and a 16-bit timer. With three words the BUSY window spans three cycles, so the bench can sample it, and a host status read can fall inside it. With four mailboxes the lock can move between two full mailboxes while the other two serve as empty, transmit and inactive cases, and as the target of a deactivation in the middle of a move.

// File: rtl/mb_lock_pkg.sv
`timescale 1ns/1ps
package mb_lock_pkg;

    typedef enum logic [1:0] {
        SEL_CS    = 2'd0,
        SEL_WORD  = 2'd1,
        SEL_TIMER = 2'd2,
        SEL_NONE  = 2'd3
    } hst_sel_e;

    localparam logic [3:0] CODE_INACTIVE = 4'b0000;
    localparam logic [3:0] CODE_EMPTY    = 4'b0100;
    localparam logic [3:0] CODE_FULL     = 4'b0010;
    localparam logic [3:0] BUSY_MASK     = 4'b0001;
    localparam int         TX_POS        = 3;

    // Receive mailbox that takes part in matching.
    function automatic logic code_is_rx_active(input logic [3:0] c);
        return !c[TX_POS] && (c != CODE_INACTIVE);
    endfunction

    // Receive mailbox holding data and not in the middle of a move.
    function automatic logic code_can_lock(input logic [3:0] c);
        return code_is_rx_active(c) && (c != CODE_EMPTY) && ((c & BUSY_MASK) == 4'b0000);
    endfunction

endpackage

// File: rtl/mb_free_timer.sv
`timescale 1ns/1ps
module mb_free_timer #(
    parameter int TIMER_W = 16
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    output logic [TIMER_W-1:0] value_o
);
    typedef struct packed {
        logic [TIMER_W-1:0] cnt;
    } tmr_state_t;

    tmr_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.cnt = st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign value_o = st_q.cnt;
endmodule

// File: rtl/mb_lock_tracker.sv
`timescale 1ns/1ps
module mb_lock_tracker #(
    parameter int NUM_MB = 4,
    parameter int IDX_W  = 2
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              rd_cs_i,
    input  logic              rd_tmr_i,
    input  logic [IDX_W-1:0]  rd_idx_i,
    input  logic              rd_lockable_i,
    input  logic [NUM_MB-1:0] deact_i,
    output logic              lock_vld_o,
    output logic [IDX_W-1:0]  lock_idx_o
);
    typedef struct packed {
        logic             vld;
        logic [IDX_W-1:0] idx;
    } lock_state_t;

    lock_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rd_tmr_i) begin
            st_d.vld = 1'b0;
        end else if (rd_cs_i && !(st_q.vld && (st_q.idx == rd_idx_i))) begin
            // Reading another mailbox drops the old lock and may take a new one.
            st_d.vld = rd_lockable_i;
            st_d.idx = rd_idx_i;
        end
        // Deactivation wins over any lock.
        if (st_d.vld && deact_i[st_d.idx]) begin
            st_d.vld = 1'b0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign lock_vld_o = st_q.vld;
    assign lock_idx_o = st_q.idx;
endmodule

// File: rtl/mb_stage_mover.sv
`timescale 1ns/1ps
module mb_stage_mover #(
    parameter int NUM_MB = 4,
    parameter int WORDS  = 2,
    parameter int DATA_W = 32,
    parameter int IDX_W  = 2,
    parameter int CNT_W  = 1
) (
    input  logic                    clk_i,
    input  logic                    rst_ni,
    input  logic                    rx_valid_i,
    input  logic [IDX_W-1:0]        rx_idx_i,
    input  logic [WORDS*DATA_W-1:0] rx_data_i,
    input  logic [NUM_MB-1:0]       deact_i,
    input  logic                    lock_vld_i,
    input  logic [IDX_W-1:0]        lock_idx_i,
    input  logic                    tgt_ok_i,
    output logic [IDX_W-1:0]        stg_idx_o,
    output logic                    start_o,
    output logic                    mv_act_o,
    output logic [IDX_W-1:0]        mv_idx_o,
    output logic [CNT_W-1:0]        mv_cnt_o,
    output logic [DATA_W-1:0]       mv_word_o,
    output logic                    mv_last_o
);
    localparam int FRAME_W = WORDS * DATA_W;

    typedef struct packed {
        logic               stg_vld;
        logic [IDX_W-1:0]   stg_idx;
        logic [FRAME_W-1:0] stg_data;
        logic               mv_act;
        logic [IDX_W-1:0]   mv_idx;
        logic [CNT_W-1:0]   mv_cnt;
        logic [FRAME_W-1:0] mv_buf;
    } mover_state_t;

    mover_state_t st_d, st_q;
    logic blocked;
    logic start;
    logic last;

    always_comb begin
        blocked = lock_vld_i && (lock_idx_i == st_q.stg_idx);
        start   = st_q.stg_vld && !st_q.mv_act && !rx_valid_i && !blocked
                  && !deact_i[st_q.stg_idx] && tgt_ok_i;
        last    = st_q.mv_act && (st_q.mv_cnt == CNT_W'(WORDS - 1));

        st_d = st_q;
        if (st_q.mv_act) begin
            st_d.mv_buf = st_q.mv_buf >> DATA_W;
            st_d.mv_cnt = st_q.mv_cnt + 1'b1;
            if (last || deact_i[st_q.mv_idx]) begin
                st_d.mv_act = 1'b0;
                st_d.mv_cnt = '0;
            end
        end

        if (start) begin
            st_d.mv_act  = 1'b1;
            st_d.mv_idx  = st_q.stg_idx;
            st_d.mv_cnt  = '0;
            st_d.mv_buf  = st_q.stg_data;
            st_d.stg_vld = 1'b0;
        end else if (st_q.stg_vld && (!tgt_ok_i || deact_i[st_q.stg_idx])) begin
            st_d.stg_vld = 1'b0;
        end

        // A fresh frame always takes the single staging slot.
        if (rx_valid_i && !deact_i[rx_idx_i]) begin
            st_d.stg_vld  = 1'b1;
            st_d.stg_idx  = rx_idx_i;
            st_d.stg_data = rx_data_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign stg_idx_o = st_q.stg_idx;
    assign start_o   = start;
    assign mv_act_o  = st_q.mv_act;
    assign mv_idx_o  = st_q.mv_idx;
    assign mv_cnt_o  = st_q.mv_cnt;
    assign mv_word_o = st_q.mv_buf[DATA_W-1:0];
    assign mv_last_o = last;
endmodule

// File: rtl/mb_lock_arbiter.sv
`timescale 1ns/1ps
module mb_lock_arbiter
    import mb_lock_pkg::*;
#(
    parameter int NUM_MB  = 4,
    parameter int WORDS   = 2,
    parameter int DATA_W  = 32,
    parameter int TIMER_W = 16,
    localparam int IDX_W  = (NUM_MB > 1) ? $clog2(NUM_MB) : 1,
    localparam int CNT_W  = (WORDS > 1) ? $clog2(WORDS) : 1
) (
    input  logic                    clk_i,
    input  logic                    rst_ni,
    input  logic                    hst_rd_en_i,
    input  logic                    hst_wr_en_i,
    input  logic [1:0]              hst_sel_i,
    input  logic [IDX_W-1:0]        hst_mb_i,
    input  logic [CNT_W-1:0]        hst_word_i,
    input  logic [DATA_W-1:0]       hst_wdata_i,
    output logic [DATA_W-1:0]       hst_rdata_o,
    input  logic                    rx_valid_i,
    input  logic [IDX_W-1:0]        rx_mb_i,
    input  logic [WORDS*DATA_W-1:0] rx_payload_i,
    input  logic [NUM_MB-1:0]       mb_deact_i
);
    typedef struct packed {
        logic [NUM_MB-1:0][3:0]                    code;
        logic [NUM_MB-1:0][WORDS-1:0][DATA_W-1:0] pay;
    } mb_state_t;

    mb_state_t st_d, st_q;

    hst_sel_e            sel;
    logic                rd_cs, rd_tmr, wr_cs;
    logic                mb_ok, word_ok;
    logic [3:0]          rd_code;
    logic                rd_lockable;
    logic                lock_vld;
    logic [IDX_W-1:0]    lock_idx;
    logic [IDX_W-1:0]    stg_idx;
    logic                start;
    logic                tgt_ok;
    logic                mv_act;
    logic [IDX_W-1:0]    mv_idx;
    logic [CNT_W-1:0]    mv_cnt;
    logic [DATA_W-1:0]   mv_word;
    logic                mv_last;
    logic [TIMER_W-1:0]  tmr_val;
    logic [DATA_W-1:0]   tmr_rd;
    logic [NUM_MB*4-1:0] code_flat;
    logic                unused_wdata_hi;

    assign sel     = hst_sel_e'(hst_sel_i);
    assign rd_cs   = hst_rd_en_i && (sel == SEL_CS);
    assign rd_tmr  = hst_rd_en_i && (sel == SEL_TIMER);
    assign wr_cs   = hst_wr_en_i && (sel == SEL_CS);
    assign mb_ok   = {{(32-IDX_W){1'b0}}, hst_mb_i} < NUM_MB;
    assign word_ok = {{(32-CNT_W){1'b0}}, hst_word_i} < WORDS;
    assign rd_code = mb_ok ? st_q.code[hst_mb_i] : CODE_INACTIVE;
    // A mailbox whose move starts this cycle is already busy for the lock decision.
    assign rd_lockable = mb_ok && code_can_lock(rd_code) && !(start && (stg_idx == hst_mb_i));
    assign tgt_ok  = ({{(32-IDX_W){1'b0}}, stg_idx} < NUM_MB) && code_is_rx_active(st_q.code[stg_idx]);
    assign code_flat = st_q.code;
    assign unused_wdata_hi = ^hst_wdata_i[DATA_W-1:4];

    mb_free_timer #(.TIMER_W(TIMER_W)) u_timer (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .value_o (tmr_val)
    );

    mb_lock_tracker #(.NUM_MB(NUM_MB), .IDX_W(IDX_W)) u_lock (
        .clk_i         (clk_i),
        .rst_ni        (rst_ni),
        .rd_cs_i       (rd_cs),
        .rd_tmr_i      (rd_tmr),
        .rd_idx_i      (hst_mb_i),
        .rd_lockable_i (rd_lockable),
        .deact_i       (mb_deact_i),
        .lock_vld_o    (lock_vld),
        .lock_idx_o    (lock_idx)
    );

    mb_stage_mover #(
        .NUM_MB (NUM_MB),
        .WORDS  (WORDS),
        .DATA_W (DATA_W),
        .IDX_W  (IDX_W),
        .CNT_W  (CNT_W)
    ) u_mover (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .rx_valid_i (rx_valid_i),
        .rx_idx_i   (rx_mb_i),
        .rx_data_i  (rx_payload_i),
        .deact_i    (mb_deact_i),
        .lock_vld_i (lock_vld),
        .lock_idx_i (lock_idx),
        .tgt_ok_i   (tgt_ok),
        .stg_idx_o  (stg_idx),
        .start_o    (start),
        .mv_act_o   (mv_act),
        .mv_idx_o   (mv_idx),
        .mv_cnt_o   (mv_cnt),
        .mv_word_o  (mv_word),
        .mv_last_o  (mv_last)
    );

    generate
        if (TIMER_W >= DATA_W) begin : g_tmr_trunc
            assign tmr_rd = tmr_val[DATA_W-1:0];
        end else begin : g_tmr_ext
            assign tmr_rd = {{(DATA_W-TIMER_W){1'b0}}, tmr_val};
        end
    endgenerate

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NUM_MB; i++) begin
            if (mb_deact_i[i]) begin
                st_d.code[i] = CODE_INACTIVE;
            end else if (mv_last && (mv_idx == IDX_W'(i))) begin
                st_d.code[i] = CODE_FULL;
            end else if (start && (stg_idx == IDX_W'(i))) begin
                st_d.code[i] = st_q.code[i] | BUSY_MASK;
            end else if (wr_cs && (hst_mb_i == IDX_W'(i)) && !(mv_act && (mv_idx == IDX_W'(i)))) begin
                st_d.code[i] = hst_wdata_i[3:0];
            end
            if (mv_act && !mb_deact_i[i] && (mv_idx == IDX_W'(i))) begin
                st_d.pay[i][mv_cnt] = mv_word;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    always_comb begin
        case (sel)
            SEL_CS:    hst_rdata_o = {{(DATA_W-4){1'b0}}, rd_code};
            SEL_WORD:  hst_rdata_o = (mb_ok && word_ok) ? st_q.pay[hst_mb_i][hst_word_i] : '0;
            SEL_TIMER: hst_rdata_o = tmr_rd;
            default:   hst_rdata_o = '0;
        endcase
    end
endmodule

// File: rtl/mb_lock_arbiter_chk.sv
`timescale 1ns/1ps
module mb_lock_arbiter_chk
    import mb_lock_pkg::*;
#(
    parameter int NUM_MB  = 4,
    parameter int IDX_W   = 2,
    parameter int TIMER_W = 16
) (
    input logic                clk_i,
    input logic                rst_ni,
    input logic                lock_vld_i,
    input logic [IDX_W-1:0]    lock_idx_i,
    input logic                mv_act_i,
    input logic [IDX_W-1:0]    mv_idx_i,
    input logic [NUM_MB*4-1:0] code_flat_i,
    input logic [NUM_MB-1:0]   deact_i,
    input logic [TIMER_W-1:0]  tmr_i
);
    logic [NUM_MB-1:0][3:0] code_now;
    logic [NUM_MB-1:0][3:0] code_prev;
    logic [3:0]             lock_code_prev;
    logic [3:0]             move_code_now;

    assign code_now       = code_flat_i;
    assign lock_code_prev = code_prev[lock_idx_i];
    assign move_code_now  = code_now[mv_idx_i];

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) code_prev <= '0;
        else         code_prev <= code_now;
    end

    // R10: timer steps by one each cycle.
    a_r10_timer_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rst_ni |=> (tmr_i == TIMER_W'($past(tmr_i) + 1'b1)));

    // R6: the mailbox under a move shows BUSY throughout.
    a_r6_busy_during_move: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mv_act_i |-> move_code_now[0]);

    // R2: no move ever targets the locked mailbox.
    a_r2_no_move_into_lock: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mv_act_i && lock_vld_i) |-> (lock_idx_i != mv_idx_i));

    // R5: a newly taken lock was granted on an eligible code.
    a_r5_lock_eligible: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (lock_vld_i && (!$past(lock_vld_i) || (lock_idx_i != $past(lock_idx_i))))
        |-> code_can_lock(lock_code_prev));

    // R8: deactivating the locked mailbox drops its lock.
    a_r8_deact_unlocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (lock_vld_i && deact_i[lock_idx_i])
        |=> !(lock_vld_i && (lock_idx_i == $past(lock_idx_i))));
endmodule

bind mb_lock_arbiter mb_lock_arbiter_chk #(
    .NUM_MB  (NUM_MB),
    .IDX_W   (IDX_W),
    .TIMER_W (TIMER_W)
) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .lock_vld_i  (lock_vld),
    .lock_idx_i  (lock_idx),
    .mv_act_i    (mv_act),
    .mv_idx_i    (mv_idx),
    .code_flat_i (code_flat),
    .deact_i     (mb_deact_i),
    .tmr_i       (tmr_val)
);

// File: tb/mb_lock_arbiter_bench.sv
`timescale 1ns/1ps
module mb_lock_arbiter_bench;
    import mb_lock_pkg::*;

    localparam int NUM_MB  = 4;
    localparam int WORDS   = 3;
    localparam int DATA_W  = 16;
    localparam int TIMER_W = 16;
    localparam int IDX_W   = 2;
    localparam int CNT_W   = 2;
    localparam real CLK_P  = 8.0;

    // Vector: {mailbox index, payload base}; word k carries base + k.
    localparam int NVEC = 6;
    localparam logic [17:0] VEC [NVEC] = '{
        {2'd0, 16'h1000}, {2'd1, 16'h2000}, {2'd2, 16'h3000},
        {2'd3, 16'h4000}, {2'd1, 16'h2100}, {2'd0, 16'h1100}
    };

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic                    hst_rd_en = 1'b0;
    logic                    hst_wr_en = 1'b0;
    logic [1:0]              hst_sel = 2'd3;
    logic [IDX_W-1:0]        hst_mb = '0;
    logic [CNT_W-1:0]        hst_word = '0;
    logic [DATA_W-1:0]       hst_wdata = '0;
    logic [DATA_W-1:0]       hst_rdata;
    logic                    rx_valid = 1'b0;
    logic [IDX_W-1:0]        rx_mb = '0;
    logic [WORDS*DATA_W-1:0] rx_payload = '0;
    logic [NUM_MB-1:0]       mb_deact = '0;

    int errors = 0;
    int checks = 0;
    logic [3:0] exp_code [NUM_MB];

    always #(CLK_P/2) clk = ~clk;

    mb_lock_arbiter #(
        .NUM_MB(NUM_MB), .WORDS(WORDS), .DATA_W(DATA_W), .TIMER_W(TIMER_W)
    ) u_mb_lock_arbiter (
        .clk_i(clk), .rst_ni(rst_n),
        .hst_rd_en_i(hst_rd_en), .hst_wr_en_i(hst_wr_en), .hst_sel_i(hst_sel),
        .hst_mb_i(hst_mb), .hst_word_i(hst_word), .hst_wdata_i(hst_wdata),
        .hst_rdata_o(hst_rdata),
        .rx_valid_i(rx_valid), .rx_mb_i(rx_mb), .rx_payload_i(rx_payload),
        .mb_deact_i(mb_deact)
    );

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic settle();
        repeat (WORDS + 3) tick();
    endtask

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic peek_code(input int i, output logic [3:0] c);
        hst_sel = SEL_CS; hst_mb = IDX_W'(i);
        #1;
        c = hst_rdata[3:0];
    endtask

    task automatic peek_word(input int i, input int w, output logic [DATA_W-1:0] v);
        hst_sel = SEL_WORD; hst_mb = IDX_W'(i); hst_word = CNT_W'(w);
        #1;
        v = hst_rdata;
    endtask

    task automatic peek_timer(output logic [DATA_W-1:0] v);
        hst_sel = SEL_TIMER;
        #1;
        v = hst_rdata;
    endtask

    task automatic read_cs(input int i);
        hst_sel = SEL_CS; hst_mb = IDX_W'(i); hst_rd_en = 1'b1;
        tick();
        hst_rd_en = 1'b0;
    endtask

    task automatic read_tmr();
        hst_sel = SEL_TIMER; hst_rd_en = 1'b1;
        tick();
        hst_rd_en = 1'b0;
    endtask

    task automatic write_code(input int i, input logic [3:0] c);
        hst_sel = SEL_CS; hst_mb = IDX_W'(i); hst_wdata = {12'h0, c}; hst_wr_en = 1'b1;
        tick();
        hst_wr_en = 1'b0;
    endtask

    task automatic send(input int i, input logic [DATA_W-1:0] base);
        for (int w = 0; w < WORDS; w++) rx_payload[w*DATA_W +: DATA_W] = base + DATA_W'(w);
        rx_mb = IDX_W'(i); rx_valid = 1'b1;
        tick();
        rx_valid = 1'b0;
    endtask

    task automatic deact(input int i);
        mb_deact = '0; mb_deact[i] = 1'b1;
        tick();
        mb_deact = '0;
    endtask

    task automatic chk_frame(input string req, input int i, input logic [DATA_W-1:0] base);
        logic [DATA_W-1:0] v;
        logic [3:0] c;
        for (int w = 0; w < WORDS; w++) begin
            peek_word(i, w, v);
            chk(req, "payload word", 32'(v), 32'(base + DATA_W'(w)));
        end
        peek_code(i, c);
        chk(req, "code after move", 32'(c), 32'(CODE_FULL));
    endtask

    task automatic chk_word0(input string req, input int i, input logic [DATA_W-1:0] exp);
        logic [DATA_W-1:0] v;
        peek_word(i, 0, v);
        chk(req, "payload word 0", 32'(v), 32'(exp));
    endtask

    initial begin
        #(CLK_P * 150000);
        errors++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [3:0] c;
        logic [DATA_W-1:0] v, t0, t1;

        repeat (3) tick();
        rst_n = 1'b1;
        tick();

        // R1: reset contents
        for (int i = 0; i < NUM_MB; i++) begin
            peek_code(i, c);
            chk("R1", "code after reset", 32'(c), 32'(CODE_INACTIVE));
            peek_word(i, 0, v);
            chk("R1", "payload after reset", 32'(v), 32'h0);
        end

        // R10: timer advances once per cycle
        peek_timer(t0);
        tick();
        peek_timer(t1);
        chk("R10", "timer step", 32'(t1), 32'(t0 + 16'd1));

        // R11: host code write
        for (int i = 0; i < NUM_MB; i++) begin
            write_code(i, CODE_EMPTY);
            exp_code[i] = CODE_EMPTY;
        end
        for (int i = 0; i < NUM_MB; i++) begin
            peek_code(i, c);
            chk("R11", "written code", 32'(c), 32'(CODE_EMPTY));
        end

        // R6: vector table of frames into unlocked mailboxes
        for (int n = 0; n < NVEC; n++) begin
            int idx;
            logic [DATA_W-1:0] base;
            idx  = int'(VEC[n][17:16]);
            base = VEC[n][15:0];
            send(idx, base);
            for (int k = 0; k < WORDS; k++) begin
                tick();
                peek_code(idx, c);
                chk("R6", "busy code during move", 32'(c), 32'(exp_code[idx] | BUSY_MASK));
            end
            tick();
            chk_frame("R6", idx, base);
            exp_code[idx] = CODE_FULL;
        end

        // R2 / R3: lock holds a frame back, timer read releases it
        read_cs(1);
        send(1, 16'h5000);
        repeat (WORDS + 4) tick();
        peek_code(1, c);
        chk("R2", "locked code", 32'(c), 32'(CODE_FULL));
        chk_word0("R2", 1, 16'h2100);
        read_tmr();
        tick();
        peek_code(1, c);
        chk("R3", "busy after release", 32'(c), 32'(CODE_FULL | BUSY_MASK));
        repeat (WORDS) tick();
        chk_frame("R3", 1, 16'h5000);

        // R4: same read keeps lock, other read moves it
        read_cs(1);
        send(1, 16'h6000);
        settle();
        chk_word0("R4", 1, 16'h5000);
        read_cs(1);
        settle();
        chk_word0("R4", 1, 16'h5000);
        read_cs(2);
        settle();
        chk_word0("R4", 1, 16'h6000);
        send(2, 16'h7000);
        settle();
        chk_word0("R4", 2, 16'h3000);
        read_tmr();
        settle();
        chk_word0("R4", 2, 16'h7000);

        // R7: staged frame replaced silently
        read_cs(0);
        send(0, 16'h8000);
        tick();
        send(0, 16'h9000);
        settle();
        chk_word0("R7", 0, 16'h1100);
        read_tmr();
        settle();
        chk_frame("R7", 0, 16'h9000);

        // R5: empty, busy, transmit and inactive reads take no lock
        write_code(3, CODE_EMPTY);
        read_cs(3);
        send(3, 16'hA000);
        settle();
        chk_word0("R5", 3, 16'hA000);
        send(3, 16'hB000);
        tick();
        read_cs(3);
        settle();
        chk_word0("R5", 3, 16'hB000);
        send(3, 16'hC000);
        settle();
        chk_word0("R5", 3, 16'hC000);
        write_code(2, 4'b1000);
        read_cs(2);
        write_code(2, CODE_EMPTY);
        send(2, 16'hD000);
        settle();
        chk_word0("R5", 2, 16'hD000);
        write_code(2, CODE_INACTIVE);
        read_cs(2);
        write_code(2, CODE_EMPTY);
        send(2, 16'hD100);
        settle();
        chk_word0("R5", 2, 16'hD100);

        // R8: deactivation during a hold
        read_cs(1);
        send(1, 16'hE000);
        tick();
        deact(1);
        peek_code(1, c);
        chk("R8", "code after deactivate", 32'(c), 32'(CODE_INACTIVE));
        write_code(1, CODE_FULL);
        settle();
        peek_code(1, c);
        chk("R8", "staged frame discarded", 32'(c), 32'(CODE_FULL));
        chk_word0("R8", 1, 16'h6000);
        send(1, 16'hF000);
        settle();
        chk_word0("R8", 1, 16'hF000);

        // R9: deactivation in the middle of a move
        send(3, 16'h1234);
        tick();
        deact(3);
        peek_code(3, c);
        chk("R9", "code after abort", 32'(c), 32'(CODE_INACTIVE));
        settle();
        peek_code(3, c);
        chk("R9", "code stays inactive", 32'(c), 32'(CODE_INACTIVE));

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule